// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a bank of 32-bit control registers inside a system-control unit. The bank holds clock-stop controls, reset controls and two hardware strap words. The registers are reached over a plain synchronous register bus. The bus carries a byte address, a write strobe with write data, and a read strobe. The block returns read data and an error flag one cycle later.

Six of the registers are set-type. A write to one of them ORs the data into the stored value. Each set-type register is paired with a clear alias one word above it. The alias has no storage of its own: writing ones to it clears the same bit positions in the register below. This lets software turn individual control bits on or off without a read-modify-write sequence.

All other words in range are ordinary read/write storage. A word index past the implemented range updates nothing and raises the error flag. The clock gating and reset generation that these bits drive are handled outside the block.

Top module: `sysctl_setclr_regs`

## Requirements
- R1: A write to a set-type word replaces the stored value with the stored value ORed with the write data. The set-type words are at byte offsets 0x040, 0x050, 0x080, 0x090, 0x500 and 0x510. Zero data bits leave stored bits unchanged.
- R2: A write to a clear alias clears every bit position that is one in the write data, in the set-type word 4 bytes below. The aliases are at 0x044, 0x054, 0x084, 0x094, 0x504 and 0x514. Bits that are zero in the data keep their value, and no other word changes.
- R3: A clear alias holds no state, and a read of an alias address returns zero.
- R4: Every other in-range word is plain read/write. A write replaces the whole stored value, and a read returns that value.
- R5: Only wr_data_i[31:0] takes part in any write. Bits 63:32 of the write data have no effect.
- R6: An access whose word index addr_i[11:2] is at or above NUM_WORDS (default 384, so byte 0x600 and up) changes no word and returns zero data, and err_o is 1 in the next cycle. An in-range access gives err_o = 0.
- R7: A synchronous reset (rst_i high at a clock edge) sets every word to zero, with two exceptions. Word 0x500 loads strap_i[31:0], and word 0x510 loads strap_i[63:32].
- R8: With RD_LAT = 1, the rd_data_o and err_o results of an access in cycle n appear in cycle n+1. rd_data_o and err_o are zero in a cycle that follows a cycle with no read and no out-of-range access.
- R9: A read and a write to the same address in the same cycle return the value held before the write. The write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strap_i | input | 2*REG_W (64) | Reset values of the two strap words, low half to 0x500 |
| addr_i | input | ADDR_W (12) | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | BUS_DW (64) | Write data, only the low REG_W bits used |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | REG_W (32) | Read data |
| err_o | output | 1 | Out-of-range access flag |

## Verification
The bench builds the block with REG_W = 32, BUS_DW = 64, ADDR_W = 12, NUM_WORDS = 384 and RD_LAT = 1. With a 64-bit bus, the upper data bits can be driven to all ones, which shows that they are truncated before the set and clear operations. A 12-bit address reaches word indices from 384 up to 1023. This makes it possible to test both sides of the range boundary: index 383 (0x5FC) must stay plain storage, and index 384 (0x600) must raise the error flag. The registered read path makes the read-during-write ordering visible, and it also shows the zero data returned in idle cycles.

// File: rtl/sysctl_regs_pkg.sv
package sysctl_regs_pkg;

   typedef enum logic [1:0] {
      K_PLAIN = 2'd0,
      K_SET   = 2'd1,
      K_CLR   = 2'd2
   } kind_e;

   // word indices (byte offset / 4) of the set-type words
   localparam int W_RST0   = 16;   // 0x040
   localparam int W_RST1   = 20;   // 0x050
   localparam int W_CLK0   = 32;   // 0x080
   localparam int W_CLK1   = 36;   // 0x090
   localparam int W_STRAP0 = 320;  // 0x500
   localparam int W_STRAP1 = 324;  // 0x510

   // smallest bank that still holds the highest clear alias
   localparam int MIN_WORDS = W_STRAP1 + 2;

   function automatic bit is_base(int w);
      return (w == W_RST0) || (w == W_RST1) || (w == W_CLK0) ||
             (w == W_CLK1) || (w == W_STRAP0) || (w == W_STRAP1);
   endfunction

   function automatic kind_e word_kind(int w);
      if (is_base(w))            return K_SET;
      else if (is_base(w - 1))   return K_CLR;
      else                       return K_PLAIN;
   endfunction

   // -1: not a strap word, otherwise slot in the strap bus
   function automatic int strap_slot(int w);
      if (w == W_STRAP0)      return 0;
      else if (w == W_STRAP1) return 1;
      else                    return -1;
   endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec #(
   parameter int ADDR_W    = 12,
   parameter int NUM_WORDS = 384,
   parameter int SEL_W     = 9
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_en_i,
   input  logic                 rd_en_i,
   output logic                 in_range_o,
   output logic [SEL_W-1:0]     sel_o,
   output logic [NUM_WORDS-1:0] wr_hit_o
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             unused_lo;

   assign idx        = addr_i[ADDR_W-1:2];
   assign unused_lo  = ^addr_i[1:0];
   assign in_range_o = (int'(idx) < NUM_WORDS);
   assign sel_o      = idx[SEL_W-1:0];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_hit
      assign wr_hit_o[w] = wr_en_i & in_range_o & (idx == IDX_W'(w));
   end

   // R2/R4: at most one word is written per cycle
   p_hit_onehot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(wr_hit_o));

   // R6: an out-of-range access selects no word
   p_oob_no_hit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      ((wr_en_i | rd_en_i) && !in_range_o) |-> (wr_hit_o == '0));

endmodule

// File: rtl/sysctl_reg_word.sv
module sysctl_reg_word #(
   parameter int REG_W    = 32,
   parameter bit SET_MODE = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [REG_W-1:0] rst_val_i,
   input  logic             wr_hit_i,
   input  logic             clr_hit_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] q_o
);
   logic [REG_W-1:0] wr_val;

   if (SET_MODE) begin : g_set
      assign wr_val = q_o | wdata_i;

      // R1: a set write keeps every previously stored one
      p_set_keeps_r1: assert property (@(posedge clk_i) disable iff (rst_i)
         (wr_hit_i && !clr_hit_i) |=> ((q_o & $past(q_o)) == $past(q_o)));

      // R1: a set write makes every data one visible
      p_set_ones_r1: assert property (@(posedge clk_i) disable iff (rst_i)
         (wr_hit_i && !clr_hit_i) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

      // R2: a clear write leaves no data-one bit set
      p_clr_bits_r2: assert property (@(posedge clk_i) disable iff (rst_i)
         clr_hit_i |=> ((q_o & $past(wdata_i)) == '0));
   end else begin : g_plain
      assign wr_val = wdata_i;

      // R4: a plain write stores exactly the data
      p_plain_store_r4: assert property (@(posedge clk_i) disable iff (rst_i)
         wr_hit_i |=> (q_o == $past(wdata_i)));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)          q_o <= rst_val_i;
      else if (clr_hit_i) q_o <= q_o & ~wdata_i;
      else if (wr_hit_i)  q_o <= wr_val;
   end

   // R6: no addressed write, no change
   p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!wr_hit_i && !clr_hit_i) |=> $stable(q_o));

endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path #(
   parameter int REG_W     = 32,
   parameter int NUM_WORDS = 384,
   parameter int SEL_W     = 9,
   parameter int RD_LAT    = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [REG_W-1:0] words_i [NUM_WORDS],
   input  logic [SEL_W-1:0] sel_i,
   input  logic             in_range_i,
   input  logic             rd_en_i,
   input  logic             wr_en_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             err_o
);
   logic [REG_W-1:0] data_now;
   logic             err_now;

   assign err_now  = (rd_en_i | wr_en_i) & ~in_range_i;
   assign data_now = (rd_en_i & in_range_i) ? words_i[sel_i] : '0;

   if (RD_LAT == 1) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            rd_data_o <= '0;
            err_o     <= 1'b0;
         end else begin
            rd_data_o <= data_now;
            err_o     <= err_now;
         end
      end

      // R6: out-of-range access flags an error one cycle later
      p_oob_err_r6: assert property (@(posedge clk_i) disable iff (rst_i)
         ((rd_en_i | wr_en_i) && !in_range_i) |=> (err_o && rd_data_o == '0));

      // R8: without a read the data bus returns to zero
      p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
         !rd_en_i |=> (rd_data_o == '0));
   end else begin : g_comb
      assign rd_data_o = data_now;
      assign err_o     = err_now;
   end

endmodule

// File: rtl/sysctl_setclr_regs.sv
module sysctl_setclr_regs
   import sysctl_regs_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int BUS_DW    = 64,
   parameter int ADDR_W    = 12,
   parameter int NUM_WORDS = 384,
   parameter int RD_LAT    = 1
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [2*REG_W-1:0]   strap_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_en_i,
   input  logic [BUS_DW-1:0]    wr_data_i,
   input  logic                 rd_en_i,
   output logic [REG_W-1:0]     rd_data_o,
   output logic                 err_o
);
   localparam int SEL_W = $clog2(NUM_WORDS);

   // elaboration-time parameter checks
   if (NUM_WORDS < MIN_WORDS) begin : g_bad_words
      $error("NUM_WORDS too small for the highest clear alias");
   end
   if (NUM_WORDS > (1 << (ADDR_W - 2))) begin : g_bad_addr
      $error("ADDR_W cannot reach NUM_WORDS words");
   end
   if (BUS_DW < REG_W) begin : g_bad_bus
      $error("BUS_DW must be at least REG_W");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("RD_LAT must be 0 or 1");
   end

   logic [REG_W-1:0]     wdata;
   logic                 unused_hi;
   logic                 in_range;
   logic [SEL_W-1:0]     sel;
   logic [NUM_WORDS-1:0] wr_hit;
   logic [NUM_WORDS-1:0] alias_mask;
   logic [REG_W-1:0]     word_q [NUM_WORDS];

   // truncate bus data to the register width
   assign wdata = wr_data_i[REG_W-1:0];
   if (BUS_DW > REG_W) begin : g_trunc
      assign unused_hi = ^wr_data_i[BUS_DW-1:REG_W];
   end else begin : g_notrunc
      assign unused_hi = 1'b0;
   end

   sysctl_addr_dec #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS),
      .SEL_W     (SEL_W)
   ) u_dec (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .addr_i     (addr_i),
      .wr_en_i    (wr_en_i),
      .rd_en_i    (rd_en_i),
      .in_range_o (in_range),
      .sel_o      (sel),
      .wr_hit_o   (wr_hit)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam kind_e KND  = word_kind(w);
      localparam int    SLOT = strap_slot(w);

      if (KND == K_CLR) begin : g_alias
         assign word_q[w]     = '0;
         assign alias_mask[w] = 1'b1;
      end else begin : g_store
         logic [REG_W-1:0] rst_val;
         logic             clr_hit;

         assign alias_mask[w] = 1'b0;

         if (SLOT >= 0) begin : g_strap
            assign rst_val = strap_i[SLOT*REG_W +: REG_W];
         end else begin : g_zero
            assign rst_val = '0;
         end

         if (KND == K_SET) begin : g_pair
            assign clr_hit = wr_hit[w+1];
         end else begin : g_solo
            assign clr_hit = 1'b0;
         end

         sysctl_reg_word #(
            .REG_W    (REG_W),
            .SET_MODE (KND == K_SET)
         ) u_word (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .rst_val_i (rst_val),
            .wr_hit_i  (wr_hit[w]),
            .clr_hit_i (clr_hit),
            .wdata_i   (wdata),
            .q_o       (word_q[w])
         );
      end
   end

   sysctl_rd_path #(
      .REG_W     (REG_W),
      .NUM_WORDS (NUM_WORDS),
      .SEL_W     (SEL_W),
      .RD_LAT    (RD_LAT)
   ) u_rd (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .words_i    (word_q),
      .sel_i      (sel),
      .in_range_i (in_range),
      .rd_en_i    (rd_en_i),
      .wr_en_i    (wr_en_i),
      .rd_data_o  (rd_data_o),
      .err_o      (err_o)
   );

   if (RD_LAT == 1) begin : g_chk
      // R3: an alias read always returns zero
      p_alias_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
         (rd_en_i && in_range && alias_mask[sel]) |=> (rd_data_o == '0));

      // R6: an in-range access never flags an error
      p_inrange_ok_r6: assert property (@(posedge clk_i) disable iff (rst_i)
         ((rd_en_i | wr_en_i) && in_range) |=> !err_o);
   end

endmodule

// File: tb/sysctl_setclr_regs_tb.sv
module sysctl_setclr_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;
   localparam int NV         = 35;
   localparam logic [1:0] OP_WR = 2'd1;
   localparam logic [1:0] OP_RD = 2'd2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] strap = 64'hA5A5_0F0F_1234_8000;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [63:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_setclr_regs u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .strap_i   (strap),
      .addr_i    (addr),
      .wr_en_i   (wr_en),
      .wr_data_i (wdata),
      .rd_en_i   (rd_en),
      .rd_data_o (rd_data),
      .err_o     (err)
   );

   // {op, addr, wdata, expected rd_data, expected err}
   localparam logic [110:0] VEC [NV] = '{
      {OP_RD, 12'h040, 64'h0, 32'h0000_0000, 1'b0},
      {OP_RD, 12'h500, 64'h0, 32'h1234_8000, 1'b0},
      {OP_RD, 12'h510, 64'h0, 32'hA5A5_0F0F, 1'b0},
      {OP_RD, 12'h084, 64'h0, 32'h0000_0000, 1'b0},
      {OP_WR, 12'h040, 64'h0000_0000_0000_00F0, 32'h0, 1'b0},
      {OP_WR, 12'h040, 64'hFFFF_FFFF_0000_0F00, 32'h0, 1'b0},
      {OP_RD, 12'h040, 64'h0, 32'h0000_0FF0, 1'b0},
      {OP_WR, 12'h044, 64'h0000_0000_0000_0030, 32'h0, 1'b0},
      {OP_RD, 12'h040, 64'h0, 32'h0000_0FC0, 1'b0},
      {OP_RD, 12'h044, 64'h0, 32'h0000_0000, 1'b0},
      {OP_RD, 12'h048, 64'h0, 32'h0000_0000, 1'b0},
      {OP_WR, 12'h080, 64'h0000_0000_DEAD_0000, 32'h0, 1'b0},
      {OP_WR, 12'h084, 64'h0000_0000_00AD_0000, 32'h0, 1'b0},
      {OP_RD, 12'h080, 64'h0, 32'hDE00_0000, 1'b0},
      {OP_WR, 12'h090, 64'h0000_0000_0000_FFFF, 32'h0, 1'b0},
      {OP_WR, 12'h094, 64'hFFFF_FFFF_0000_0F0F, 32'h0, 1'b0},
      {OP_RD, 12'h090, 64'h0, 32'h0000_F0F0, 1'b0},
      {OP_WR, 12'h050, 64'h0000_0000_0000_0001, 32'h0, 1'b0},
      {OP_WR, 12'h054, 64'h0000_0000_0000_0002, 32'h0, 1'b0},
      {OP_RD, 12'h050, 64'h0, 32'h0000_0001, 1'b0},
      {OP_WR, 12'h504, 64'h0000_0000_0000_8000, 32'h0, 1'b0},
      {OP_RD, 12'h500, 64'h0, 32'h1234_0000, 1'b0},
      {OP_WR, 12'h510, 64'h0000_0000_0000_0010, 32'h0, 1'b0},
      {OP_RD, 12'h510, 64'h0, 32'hA5A5_0F1F, 1'b0},
      {OP_WR, 12'h100, 64'h0000_0000_1111_1111, 32'h0, 1'b0},
      {OP_WR, 12'h100, 64'h0000_0000_2222_0000, 32'h0, 1'b0},
      {OP_RD, 12'h100, 64'h0, 32'h2222_0000, 1'b0},
      {OP_WR, 12'h600, 64'h0000_0000_FFFF_FFFF, 32'h0, 1'b1},
      {OP_RD, 12'h600, 64'h0, 32'h0000_0000, 1'b1},
      {OP_RD, 12'h000, 64'h0, 32'h0000_0000, 1'b0},
      {OP_RD, 12'h5FC, 64'h0, 32'h0000_0000, 1'b0},
      {OP_WR, 12'h5FC, 64'h0000_0000_CAFE_F00D, 32'h0, 1'b0},
      {OP_RD, 12'h5FC, 64'h0, 32'hCAFE_F00D, 1'b0},
      {OP_WR, 12'hFFC, 64'h0000_0000_1234_5678, 32'h0, 1'b1},
      {OP_RD, 12'h3FC, 64'h0, 32'h0000_0000, 1'b0}
   };

   localparam string TAG [NV] = '{
      "R7", "R7", "R7", "R3", "R1", "R5", "R1", "R2", "R2", "R3",
      "R2", "R1", "R2", "R2", "R1", "R5", "R2", "R1", "R2", "R2",
      "R2", "R2", "R1", "R1", "R4", "R4", "R4", "R6", "R6", "R6",
      "R6", "R4", "R4", "R6", "R6"
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive one access, then sample its registered result one cycle later
   task automatic access(input logic wr, input logic rd, input logic [11:0] a,
                         input logic [63:0] d, input logic [31:0] exp_d,
                         input logic exp_e, input string tag);
      @(negedge clk);
      wr_en = wr; rd_en = rd; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
      check(tag, "rd_data", rd_data, exp_d);
      check(tag, "err", {31'b0, err}, {31'b0, exp_e});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][110:109] == OP_WR, VEC[i][110:109] == OP_RD,
                VEC[i][108:97], VEC[i][96:33], VEC[i][32:1], VEC[i][0], TAG[i]);
      end

      // R8: a cycle after an idle cycle shows zero data and no error
      @(negedge clk);
      check("R8", "idle rd_data", rd_data, 32'h0);
      check("R8", "idle err", {31'b0, err}, 32'h0);

      // R9: read and write in the same cycle return the old value
      access(1'b1, 1'b1, 12'h040, 64'h1, 32'h0000_0FC0, 1'b0, "R9");
      access(1'b0, 1'b1, 12'h040, 64'h0, 32'h0000_0FC1, 1'b0, "R9");

      // R9: same-cycle clear on an alias, then read of the base
      access(1'b1, 1'b1, 12'h084, 64'hDE00_0000, 32'h0, 1'b0, "R9");
      access(1'b0, 1'b1, 12'h080, 64'h0, 32'h0, 1'b0, "R9");

      // R7: reset mid-run with a new strap value
      @(negedge clk);
      strap = 64'h0000_0001_8000_0000;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check("R7", "rd_data after reset", rd_data, 32'h0);
      access(1'b0, 1'b1, 12'h500, 64'h0, 32'h8000_0000, 1'b0, "R7");
      access(1'b0, 1'b1, 12'h510, 64'h0, 32'h0000_0001, 1'b0, "R7");
      access(1'b0, 1'b1, 12'h040, 64'h0, 32'h0, 1'b0, "R7");
      access(1'b0, 1'b1, 12'h5FC, 64'h0, 32'h0, 1'b0, "R7");
      access(1'b0, 1'b1, 12'h100, 64'h0, 32'h0, 1'b0, "R7");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule